// File: doc/BRIEF.md
# Scanline Sprite Evaluation Unit

This block decides which of the 64 hardware sprites of a tile-based video generator appear on the scanline being prepared. It reads the sprite attribute memory through a single read port with one cycle of latency. That memory holds 256 bytes, four bytes per sprite. Within a sprite entry, byte offset 0 is the Y coordinate, offset 1 the tile index, offset 2 the attribute byte and offset 3 the X coordinate.

The work runs in two phases keyed to the dot counter. During the visible dots 0..255 the block reads only the Y byte of each sprite, one sprite every 4 dots. It keeps the memory index of each sprite whose Y places it on the prepared line, up to eight of them. During the blank dots 256..319 the block fetches the tile, attribute and X bytes of the kept sprites into eight output slots, and the renderer reads those slots for its next line. Because the slots are written only inside that window, the renderer can read them throughout the visible dots with no second bank. Slots left without a sprite hold a transparent marker. A ninth or later match on a line sets a sticky overflow flag, which is cleared by a frame-start pulse.

Top module: `sprite_line_eval`

## Requirements
- R1: At a visible dot d (d < 256) with d mod 4 = 0, `mem_addr` is 4*(d/4), which is the Y byte (offset 0) of sprite d/4. Read data is expected one clock later.
- R2: A sprite is in range when (line - Y) taken modulo 512 is between 0 and 7. A Y above the line, or 8 or more below it, produces no slot.
- R3: Up to 8 in-range sprites fill slots 0..7 in ascending sprite-index order. After dot 319, slot k holds the tile byte (offset 1), attribute byte (offset 2) and X byte (offset 3) of the k-th in-range sprite, in bits [8k+7:8k] of `slot_tile`, `slot_attr` and `slot_x`.
- R4: Every slot not filled on a line has all three bytes set to 8'hFF, including slots that were filled on an earlier line.
- R5: `sprite_ovf` rises when a line has more than 8 in-range sprites. It stays set over later lines until a cycle with `frame_start` high, which clears it on the next edge, and clearing wins over setting.
- R6: The slot outputs change only on the clock edge that ends a cycle whose dot lies in 256..319. Everywhere else they hold their values, including during all visible dots.
- R7: While reset is held, and after it, all slots read 8'hFF and `sprite_ovf` is 0 until a line is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame; clears the overflow flag |
| dot | input | 9 | Dot counter within the line (0..340) |
| line | input | 9 | Number of the scanline being prepared |
| mem_addr | output | 8 | Sprite attribute memory read address |
| mem_rdata | input | 8 | Read data, valid one clock after the address |
| slot_tile | output | 64 | Tile index of slots 0..7, 8 bits each |
| slot_attr | output | 64 | Attribute byte of slots 0..7, 8 bits each |
| slot_x | output | 64 | X coordinate of slots 0..7, 8 bits each |
| sprite_ovf | output | 1 | More than 8 sprites matched since the last frame start |

## Verification
The assertions check several properties on every cycle. The Y-byte address pattern must follow the dot counter. The stored count never goes past eight. An out-of-range Y never grows the count. The overflow flag keeps its value or clears exactly as `frame_start` dictates. The slots stay unchanged outside the fetch window. Whether the right sprites land in the right slots, in index order and with the right bytes, depends on memory contents across a whole line. The bench covers this with directed cases: the in-range boundary at 0 and 7, a Y above the line, exactly eight matches, nine or more matches, and empty lines after full ones. Random lines are checked against a reference computed from the memory image.

// File: rtl/sle_pkg.sv
package sle_pkg;
  // byte offsets inside a 4-byte sprite entry; the fetch order depends on them
  localparam int OFS_Y    = 0;
  localparam int OFS_TILE = 1;
  localparam int OFS_ATTR = 2;
  localparam int OFS_X    = 3;

  localparam logic [7:0] EMPTY_BYTE = 8'hFF;

  typedef struct packed {
    logic [7:0] tile;
    logic [7:0] attr;
    logic [7:0] xpos;
  } slot_t;
endpackage

// File: rtl/sle_dot_decode.sv
module sle_dot_decode #(
  parameter int DOT_W      = 9,
  parameter int NUM_SPR    = 64,
  parameter int SLOTS      = 8,
  parameter int VIS_DOTS   = 256,
  parameter int FETCH_DOTS = 64,
  localparam int IDX_W  = $clog2(NUM_SPR),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CSH    = $clog2(VIS_DOTS / NUM_SPR),
  localparam int FSH    = $clog2(FETCH_DOTS / SLOTS)
) (
  input  logic [DOT_W-1:0]  dot,
  output logic              line_start,
  output logic              cmp_issue,
  output logic              cmp_take,
  output logic [IDX_W-1:0]  cmp_spr,
  output logic              fetch_act,
  output logic [SLOT_W-1:0] fetch_slot,
  output logic [FSH-1:0]    fetch_phase
);
  localparam int FW = SLOT_W + FSH;

  logic          in_vis;
  logic [CSH-1:0] sub;
  logic [FW-1:0] rel;

  always_comb begin
    in_vis      = dot < DOT_W'(VIS_DOTS);
    sub         = dot[CSH-1:0];
    cmp_spr     = dot[CSH +: IDX_W];
    line_start  = dot == '0;
    cmp_issue   = in_vis && (sub == '0);
    cmp_take    = in_vis && (sub == CSH'(1));
    fetch_act   = (dot >= DOT_W'(VIS_DOTS)) && (dot < DOT_W'(VIS_DOTS + FETCH_DOTS));
    rel         = FW'(dot - DOT_W'(VIS_DOTS));
    fetch_slot  = rel[FW-1:FSH];
    fetch_phase = rel[FSH-1:0];
  end
endmodule

// File: rtl/sle_collect.sv
module sle_collect #(
  parameter int NUM_SPR = 64,
  parameter int SLOTS   = 8,
  parameter int SPR_H   = 8,
  parameter int LINE_W  = 9,
  localparam int IDX_W  = $clog2(NUM_SPR),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              take,
  input  logic [IDX_W-1:0]  spr_idx,
  input  logic [7:0]        y_byte,
  input  logic [LINE_W-1:0] line,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  count,
  output logic              overflow
);
  logic [IDX_W-1:0]  idx_mem [SLOTS];
  logic [LINE_W-1:0] diff;
  logic              hit;
  logic              room;

  always_comb begin
    diff = line - LINE_W'(y_byte);
    hit  = diff < LINE_W'(SPR_H);
    room = count < CNT_W'(SLOTS);
  end

  always_ff @(posedge clk) begin
    if (take && hit && room)
      idx_mem[SLOT_W'(count)] <= spr_idx;
  end

  assign rd_idx = idx_mem[rd_slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (line_start)
        count <= '0;
      else if (take && hit) begin
        if (room) count <= count + 1'b1;
        else      overflow <= 1'b1;
      end
      if (frame_start)
        overflow <= 1'b0;
    end
  end

  // R3
  slot_cap_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(SLOTS));

  // R2
  miss_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !hit) |=> count == $past(count));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !frame_start) |=> overflow);

  // R5
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !overflow);
endmodule

// File: rtl/sle_slot_buf.sv
module sle_slot_buf #(
  parameter int NUM_SPR    = 64,
  parameter int SLOTS      = 8,
  parameter int FETCH_DOTS = 64,
  localparam int IDX_W  = $clog2(NUM_SPR),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int FSH    = $clog2(FETCH_DOTS / SLOTS),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetch_act,
  input  logic [SLOT_W-1:0]    fetch_slot,
  input  logic [FSH-1:0]       fetch_phase,
  input  logic [CNT_W-1:0]     count,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           rdata,
  output logic [ADDR_W-1:0]    fetch_addr,
  output sle_pkg::slot_t       slots_o [SLOTS]
);
  import sle_pkg::*;

  logic       filled;
  logic       issue;
  logic [7:0] byte_in;

  always_comb begin
    filled     = CNT_W'(fetch_slot) < count;
    issue      = fetch_act && (fetch_phase < FSH'(3));
    fetch_addr = issue ? {idx, 2'(fetch_phase) + 2'd1} : '0;
    byte_in    = filled ? rdata : EMPTY_BYTE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++)
        slots_o[i] <= '{tile: EMPTY_BYTE, attr: EMPTY_BYTE, xpos: EMPTY_BYTE};
    end else if (fetch_act) begin
      if (fetch_phase == FSH'(OFS_TILE)) slots_o[fetch_slot].tile <= byte_in;
      if (fetch_phase == FSH'(OFS_ATTR)) slots_o[fetch_slot].attr <= byte_in;
      if (fetch_phase == FSH'(OFS_X))    slots_o[fetch_slot].xpos <= byte_in;
    end
  end
endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval #(
  parameter int DOT_W      = 9,
  parameter int LINE_W     = 9,
  parameter int NUM_SPR    = 64,
  parameter int SLOTS      = 8,
  parameter int SPR_H      = 8,
  parameter int VIS_DOTS   = 256,
  parameter int FETCH_DOTS = 64,
  localparam int IDX_W  = $clog2(NUM_SPR),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_start,
  input  logic [DOT_W-1:0]     dot,
  input  logic [LINE_W-1:0]    line,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic [7:0]           mem_rdata,
  output logic [SLOTS*8-1:0]   slot_tile,
  output logic [SLOTS*8-1:0]   slot_attr,
  output logic [SLOTS*8-1:0]   slot_x,
  output logic                 sprite_ovf
);
  import sle_pkg::*;

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int CSH    = $clog2(VIS_DOTS / NUM_SPR);
  localparam int FSH    = $clog2(FETCH_DOTS / SLOTS);

  logic              line_start, cmp_issue, cmp_take, fetch_act;
  logic [IDX_W-1:0]  cmp_spr, rd_idx;
  logic [SLOT_W-1:0] fetch_slot;
  logic [FSH-1:0]    fetch_phase;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] fetch_addr;
  slot_t             slots [SLOTS];

  sle_dot_decode #(.DOT_W(DOT_W), .NUM_SPR(NUM_SPR), .SLOTS(SLOTS),
                   .VIS_DOTS(VIS_DOTS), .FETCH_DOTS(FETCH_DOTS)) u_dec (
    .dot(dot), .line_start(line_start), .cmp_issue(cmp_issue), .cmp_take(cmp_take),
    .cmp_spr(cmp_spr), .fetch_act(fetch_act), .fetch_slot(fetch_slot),
    .fetch_phase(fetch_phase));

  sle_collect #(.NUM_SPR(NUM_SPR), .SLOTS(SLOTS), .SPR_H(SPR_H), .LINE_W(LINE_W)) u_col (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .take(cmp_take), .spr_idx(cmp_spr), .y_byte(mem_rdata), .line(line),
    .rd_slot(fetch_slot), .rd_idx(rd_idx), .count(count), .overflow(sprite_ovf));

  sle_slot_buf #(.NUM_SPR(NUM_SPR), .SLOTS(SLOTS), .FETCH_DOTS(FETCH_DOTS)) u_buf (
    .clk(clk), .rst(rst), .fetch_act(fetch_act), .fetch_slot(fetch_slot),
    .fetch_phase(fetch_phase), .count(count), .idx(rd_idx), .rdata(mem_rdata),
    .fetch_addr(fetch_addr), .slots_o(slots));

  assign mem_addr = cmp_issue ? {cmp_spr, 2'(OFS_Y)} : fetch_addr;

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign slot_tile[g*8 +: 8] = slots[g].tile;
    assign slot_attr[g*8 +: 8] = slots[g].attr;
    assign slot_x[g*8 +: 8]    = slots[g].xpos;
  end

  // R1
  y_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (dot < DOT_W'(VIS_DOTS) && dot[CSH-1:0] == '0) |->
      (mem_addr[ADDR_W-1:2] == dot[CSH +: IDX_W] && mem_addr[1:0] == 2'd0));

  // R6
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(dot) >= DOT_W'(VIS_DOTS) &&
                      $past(dot) < DOT_W'(VIS_DOTS + FETCH_DOTS))) |->
      ($stable(slot_tile) && $stable(slot_attr) && $stable(slot_x)));
endmodule

// File: tb/tb_sprite_line_eval.sv
module tb_sprite_line_eval;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [8:0]  dot = 9'd340;
  logic [8:0]  line = '0;
  logic [7:0]  mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [63:0] slot_tile, slot_attr, slot_x;
  logic        sprite_ovf;

  logic [7:0]  mem [256];
  logic [63:0] exp_tile, exp_attr, exp_x;
  logic        exp_ovf = 1'b0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) mem_rdata <= mem[mem_addr];

  sprite_line_eval dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .dot(dot), .line(line),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .slot_tile(slot_tile),
    .slot_attr(slot_attr), .slot_x(slot_x), .sprite_ovf(sprite_ovf));

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic compute_exp(input int ln);
    int n = 0;
    exp_tile = '1; exp_attr = '1; exp_x = '1;
    for (int i = 0; i < 64; i++) begin
      logic [8:0] d;
      d = 9'(ln) - {1'b0, mem[4*i]};
      if (d < 9'd8) begin
        if (n < 8) begin
          exp_tile[n*8 +: 8] = mem[4*i+1];
          exp_attr[n*8 +: 8] = mem[4*i+2];
          exp_x[n*8 +: 8]    = mem[4*i+3];
        end
        n++;
      end
    end
    if (n > 8) exp_ovf = 1'b1;
  endtask

  task automatic run_line(input int ln, input string tag);
    logic [63:0] prev_t, prev_a, prev_x;
    compute_exp(ln);
    prev_t = slot_tile; prev_a = slot_attr; prev_x = slot_x;
    line = 9'(ln);
    for (int d = 0; d <= 340; d++) begin
      @(negedge clk);
      dot = 9'(d);
      if (d == 20) begin
        #1;
        check(mem_addr == 8'd20, "R1 Y address of sprite 5", 64'(mem_addr), 64'd20);
      end
      if (d == 200) begin
        check(slot_tile == prev_t && slot_attr == prev_a && slot_x == prev_x,
              "R6 slots held during visible dots", slot_tile, prev_t);
      end
    end
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      check(slot_tile[k*8 +: 8] == exp_tile[k*8 +: 8] &&
            slot_attr[k*8 +: 8] == exp_attr[k*8 +: 8] &&
            slot_x[k*8 +: 8]    == exp_x[k*8 +: 8],
            $sformatf("R2/R3/R4 %s slot %0d {tile,attr,x}", tag, k),
            {40'd0, slot_tile[k*8 +: 8], slot_attr[k*8 +: 8], slot_x[k*8 +: 8]},
            {40'd0, exp_tile[k*8 +: 8], exp_attr[k*8 +: 8], exp_x[k*8 +: 8]});
    end
    check(sprite_ovf == exp_ovf, {"R5 overflow flag ", tag}, 64'(sprite_ovf), 64'(exp_ovf));
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    exp_ovf = 1'b0;
  endtask

  task automatic fill_far();
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 64; i++) mem[4*i] = 8'hFF;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete (all requirements) act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    check(slot_tile == '1 && slot_attr == '1 && slot_x == '1, "R7 slots empty in reset",
          slot_tile, '1);
    rst = 1'b0;
    @(negedge clk);
    check(slot_tile == '1 && slot_x == '1 && !sprite_ovf, "R7 state after reset",
          {63'd0, sprite_ovf}, 64'd0);

    // R4: nothing in range
    fill_far();
    run_line(120, "empty line");

    // R2: boundaries at 0 and 7, one Y 8 below, one Y above the line
    fill_far();
    mem[4*3]  = 8'd100;
    mem[4*10] = 8'd93;
    mem[4*11] = 8'd92;
    mem[4*20] = 8'd101;
    run_line(100, "range boundaries");

    // R2: Y above a low line wraps out of range
    fill_far();
    for (int i = 0; i < 64; i += 5) mem[4*i] = 8'd250;
    run_line(2, "wrap");

    // R3: exactly eight matches
    fill_far();
    for (int i = 0; i < 8; i++) mem[4*(5 + 7*i)] = 8'(50 - i);
    run_line(50, "eight matches");

    // R5: twelve matches, first eight kept by index order
    fill_far();
    for (int i = 0; i < 12; i++) mem[4*(2 + 5*i)] = 8'(77 - (i % 8));
    run_line(77, "twelve matches");

    // R4/R5: empty line keeps flag, stale slots cleared
    fill_far();
    run_line(78, "after overflow");
    pulse_frame();
    run_line(10, "after frame start");

    // random lines
    for (int r = 0; r < 24; r++) begin
      int ln;
      ln = 10 + int'($urandom % 220);
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
      for (int i = 0; i < 64; i++)
        mem[4*i] = ($urandom % 3 == 0) ? 8'(ln - int'($urandom % 12)) : 8'($urandom);
      if (r % 6 == 5) pulse_frame();
      run_line(ln, $sformatf("random %0d", r));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule